// File: doc/BRIEF.md
# Four-State Radix-2 Path Metric Update Array

This block is the recursive core of a hard- or soft-input trellis decoder for a rate-1/2 convolutional code with two memory elements, octal generators 7 and 5. It keeps one accumulated metric per trellis state. On every cycle in which the input strobe is high, it extends each state's two incoming branches by their supplied branch costs, keeps the cheaper one as the state's new metric, and reports which predecessor won as one decision bit per state. A survivor memory downstream consumes the decision vector. Branch costs are computed outside the block.

State numbering puts the most recent information bit in the most significant position of the state index. Metrics are never rescaled. They wrap modulo the accumulator width, and survivors are picked from the sign of a modular difference, so the comparison stays right as long as all live metrics lie within half the modular range of each other. After reset, state 0 starts at zero and every other state starts at a large seed, so decoding begins from the all-zero encoder state.

Top module: `acs_array_r2`

## Requirements
- R1: While reset is low at a clock edge, the state 0 metric becomes 0, every other state metric becomes INIT_FAR (default 32), dec_o becomes all zeros and dec_vld_o becomes 0.
- R2: On an accepted cycle, each state's new metric is the smaller of its two candidates, where a candidate is the predecessor's metric plus the connecting branch cost, taken modulo 2^MW (default MW = 8).
- R3: Decision bit s is 1 when the candidate from the odd-numbered predecessor is strictly smaller, and 0 otherwise, so equal candidates keep the even-numbered predecessor.
- R4: State s (index bits newest first) has predecessors {s[0],0} (even) and {s[0],1} (odd). The cost of the branch from predecessor b (0 even, 1 odd) into state s sits at bm_in[(2*s+b)*BW +: BW], with BW = 5 by default.
- R5: Metrics wrap without rescaling. The survivor is chosen by the sign bit of the MW-bit difference of the candidates, so it matches true unbounded arithmetic whenever the candidates differ by less than 2^(MW-1), including when one of them has wrapped past zero.
- R6: On a cycle with in_valid low, sm_o and dec_o keep their values and dec_vld_o is 0 on the next cycle.
- R7: The metrics and decisions for an accepted cycle appear on sm_o and dec_o one clock after that edge, with dec_vld_o high in exactly that cycle.
- R8: All states are updated on every accepted cycle, and back-to-back accepted cycles each give their own result with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Branch costs on bm_in are valid this cycle |
| bm_in | input | 2*2^MEM*BW | Branch costs, lane 2*s+b for the branch from predecessor b into state s |
| dec_vld_o | output | 1 | dec_o and sm_o carry a fresh update |
| dec_o | output | 2^MEM | One survivor decision per state, 1 means odd-numbered predecessor |
| sm_o | output | 2^MEM*MW | Current state metrics, state s at bits [s*MW +: MW] |

## Verification
Two functions can coincide in one cycle: a metric wrapping past the top of the accumulator and the survivor comparison that has to choose across that wrap. The bench runs long encoded streams with injected bit errors and a burst of maximum branch costs, so metrics cross the modular boundary many times with neighbouring states on both sides of it. Each result is judged against a model that keeps metrics as unbounded integers and compares them directly. The model also counts the cases where plain unsigned comparison of the wrapped values would pick the wrong survivor, and the run must contain some. Ties, which exercise the even-predecessor rule, arise naturally in hard-decision costs and are counted and checked the same way.

// File: rtl/acs_pkg.sv
// Package: trellis connectivity helpers shared by the path metric array.
// Assumes state indices carry the newest information bit in the MSB.
package acs_pkg;

    // Predecessor of state ns through branch b (0 = even/upper, 1 = odd/lower).
    function automatic int pred_state(input int ns, input int b, input int mem);
        return ((ns << 1) & ((1 << mem) - 1)) | (b & 1);
    endfunction

    // Lane index of the branch cost from predecessor b into state ns.
    function automatic int lane_of(input int ns, input int b);
        return 2 * ns + b;
    endfunction

endpackage

// File: rtl/acs_cell.sv
// Module: acs_cell
// One add-compare-select element. Adds a branch cost to each of the two
// predecessor metrics, compares the candidates by modular subtraction and
// passes on the smaller one with a decision bit.
// Assumes live metrics stay within 2^(MW-1) of each other and MW > BW.
module acs_cell #(
    parameter int MW = 8,
    parameter int BW = 5
) (
    input  logic [MW-1:0] pm_up,
    input  logic [MW-1:0] pm_lo,
    input  logic [BW-1:0] bm_up,
    input  logic [BW-1:0] bm_lo,
    output logic [MW-1:0] pm_new,
    output logic          dec
);

    logic [MW-1:0] cand_up;
    logic [MW-1:0] cand_lo;
    logic [MW-1:0] gap;

    // Add, subtract and select; the sign of the modular gap picks the survivor.
    always_comb begin
        cand_up = pm_up + MW'(bm_up);
        cand_lo = pm_lo + MW'(bm_lo);
        gap     = cand_lo - cand_up;
        dec     = gap[MW-1];
        pm_new  = dec ? cand_lo : cand_up;
    end

endmodule

// File: rtl/acs_metric_bank.sv
// Module: acs_metric_bank
// Register bank for the state metrics and the decision vector. Loads on
// accepted cycles only, seeds the metrics on reset and flags fresh results.
// Assumes synchronous active-low reset.
module acs_metric_bank #(
    parameter int NS       = 4,
    parameter int MW       = 8,
    parameter int INIT_FAR = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NS*MW-1:0] pm_next,
    input  logic [NS-1:0]    dec_next,
    output logic [NS*MW-1:0] pm_q,
    output logic [NS-1:0]    dec_q,
    output logic             vld_q
);

    // Seed on reset, load on accepted cycles, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                pm_q[s*MW +: MW] <= (s == 0) ? '0 : MW'(INIT_FAR);
            end
            dec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= en;
            if (en) begin
                pm_q  <= pm_next;
                dec_q <= dec_next;
            end
        end
    end

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pm_q) && $stable(dec_q) && !vld_q));

    // R7
    fresh_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> vld_q);

endmodule

// File: rtl/acs_array_r2.sv
// Module: acs_array_r2
// Path metric update for a 2^MEM-state radix-2 trellis. One acs_cell per
// state, wired by trellis connectivity, feeding a registered metric bank.
// Assumes branch costs arrive lane 2*s+b and metric spread < 2^(MW-1).
module acs_array_r2 #(
    parameter int MEM      = 2,
    parameter int MW       = 8,
    parameter int BW       = 5,
    parameter int INIT_FAR = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2*(1<<MEM)*BW-1:0]    bm_in,
    output logic                        dec_vld_o,
    output logic [(1<<MEM)-1:0]         dec_o,
    output logic [(1<<MEM)*MW-1:0]      sm_o
);

    localparam int NS = 1 << MEM;

    logic [NS*MW-1:0] pm_next;
    logic [NS-1:0]    dec_next;
    logic [MW-1:0]    sm_q [NS];

    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam int P0 = acs_pkg::pred_state(s, 0, MEM);
        localparam int P1 = acs_pkg::pred_state(s, 1, MEM);
        localparam int L0 = acs_pkg::lane_of(s, 0);
        localparam int L1 = acs_pkg::lane_of(s, 1);

        assign sm_q[s] = sm_o[s*MW +: MW];

        acs_cell #(.MW(MW), .BW(BW)) u_cell (
            .pm_up (sm_o[P0*MW +: MW]),
            .pm_lo (sm_o[P1*MW +: MW]),
            .bm_up (bm_in[L0*BW +: BW]),
            .bm_lo (bm_in[L1*BW +: BW]),
            .pm_new(pm_next[s*MW +: MW]),
            .dec   (dec_next[s])
        );

        // R2
        min_survivor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=>
                ($signed(MW'(sm_q[s] - MW'($past(sm_q[P0]) + MW'($past(bm_in[L0*BW +: BW]))))) <= 0) &&
                ($signed(MW'(sm_q[s] - MW'($past(sm_q[P1]) + MW'($past(bm_in[L1*BW +: BW]))))) <= 0));

        // R3
        decision_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (sm_q[s] == (dec_o[s]
                ? MW'($past(sm_q[P1]) + MW'($past(bm_in[L1*BW +: BW])))
                : MW'($past(sm_q[P0]) + MW'($past(bm_in[L0*BW +: BW]))))));
    end

    acs_metric_bank #(.NS(NS), .MW(MW), .INIT_FAR(INIT_FAR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_valid),
        .pm_next (pm_next),
        .dec_next(dec_next),
        .pm_q    (sm_o),
        .dec_q   (dec_o),
        .vld_q   (dec_vld_o)
    );

endmodule

// File: tb/acs_array_r2_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for acs_array_r2. A driver encodes random bits with the
// 7/5 code, injects errors, forms Hamming branch costs and pushes results of
// an unbounded-integer model; a monitor pops and compares each output.
module acs_array_r2_test;

    localparam int MEM = 2;
    localparam int NS  = 1 << MEM;
    localparam int MW  = 8;
    localparam int BW  = 5;
    localparam int FAR = 32;
    localparam int LW  = 2 * NS * BW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [LW-1:0]    bm_in = '0;
    logic             dec_vld_o;
    logic [NS-1:0]    dec_o;
    logic [NS*MW-1:0] sm_o;

    always #2 clk = ~clk;

    acs_array_r2 #(.MEM(MEM), .MW(MW), .BW(BW), .INIT_FAR(FAR)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bm_in(bm_in),
        .dec_vld_o(dec_vld_o), .dec_o(dec_o), .sm_o(sm_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ties = 0;
    int wraps = 0;
    int mm [NS];
    logic [NS+NS*MW-1:0] exp_q [$];
    logic [NS*MW-1:0] hold_sm;
    logic [NS-1:0]    hold_dec;
    logic             samp_v = 1'b0;
    logic [1:0]       enc_st = 2'b00;

    task automatic fail(input string req, input logic [63:0] got, input logic [63:0] exp);
        errors++;
        $display("FAIL %s: got %h expected %h", req, got, exp);
    endtask

    function automatic logic [NS*MW-1:0] pack_mm();
        logic [NS*MW-1:0] r;
        for (int s = 0; s < NS; s++) r[s*MW +: MW] = MW'(mm[s]);
        return r;
    endfunction

    // Hamming branch costs for received pair (r0, r1), per R4 lane layout.
    function automatic logic [LW-1:0] hard_lanes(input bit r0, input bit r1);
        logic [LW-1:0] l;
        for (int ns = 0; ns < NS; ns++) begin
            for (int b = 0; b < 2; b++) begin
                int p;
                int u;
                int e0;
                int e1;
                int c;
                p  = ((ns << 1) & (NS - 1)) | b;
                u  = ns >> 1;
                e0 = u ^ ((p >> 1) & 1) ^ (p & 1);
                e1 = u ^ (p & 1);
                c  = ((e0 != int'(r0)) ? 1 : 0) + ((e1 != int'(r1)) ? 1 : 0);
                l[(2*ns+b)*BW +: BW] = BW'(c);
            end
        end
        return l;
    endfunction

    // Drive one cycle; on valid, advance the model and push the expectation.
    task automatic step(input bit v, input logic [LW-1:0] lanes);
        @(negedge clk);
        in_valid = v;
        bm_in = lanes;
        if (v) begin
            int nm [NS];
            logic [NS-1:0] d;
            for (int ns = 0; ns < NS; ns++) begin
                int p0;
                int c0;
                int c1;
                p0 = (ns << 1) & (NS - 1);
                c0 = mm[p0] + int'(lanes[(2*ns)*BW +: BW]);
                c1 = mm[p0 | 1] + int'(lanes[(2*ns+1)*BW +: BW]);
                if (((c0 % (1 << MW)) < (c1 % (1 << MW))) != (c0 < c1)) wraps++;
                if (c0 == c1) ties++;
                d[ns]  = (c1 < c0);
                nm[ns] = d[ns] ? c1 : c0;
            end
            mm = nm;
            exp_q.push_back({d, pack_mm()});
        end
    endtask

    task automatic send_bit(input bit u);
        bit c0;
        bit c1;
        c0 = u ^ enc_st[1] ^ enc_st[0];
        c1 = u ^ enc_st[0];
        enc_st = {u, enc_st[1]};
        if ($urandom % 6 == 0) c0 = ~c0;
        if ($urandom % 6 == 0) c1 = ~c1;
        step(1'b1, hard_lanes(c0, c1));
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 8 == 0) step(1'b0, '0);
            else send_bit(1'($urandom % 2));
        end
    endtask

    always @(posedge clk) samp_v <= rst_n & in_valid;

    // Monitor: pop and compare each fresh result; check holds when idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dec_vld_o !== samp_v) fail("R7 result flag", 64'(dec_vld_o), 64'(samp_v));
            if (dec_vld_o) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fail("R8 unexpected result", 64'(sm_o), 64'd0);
                end else begin
                    logic [NS+NS*MW-1:0] it;
                    it = exp_q.pop_front();
                    checks++;
                    if (sm_o !== it[NS*MW-1:0]) fail("R2,R4,R5 metrics", 64'(sm_o), 64'(it[NS*MW-1:0]));
                    if (dec_o !== it[NS+NS*MW-1:NS*MW]) fail("R3 decisions", 64'(dec_o), 64'(it[NS+NS*MW-1:NS*MW]));
                    hold_sm  = it[NS*MW-1:0];
                    hold_dec = it[NS+NS*MW-1:NS*MW];
                end
            end else begin
                checks++;
                if (sm_o !== hold_sm || dec_o !== hold_dec)
                    fail("R6 hold while idle", 64'({dec_o, sm_o}), 64'({hold_dec, hold_sm}));
            end
        end
    end

    initial begin
        mm[0] = 0;
        for (int s = 1; s < NS; s++) mm[s] = FAR;
        hold_sm  = pack_mm();
        hold_dec = '0;
        repeat (3) @(negedge clk);
        // R1: reset seeds
        checks++;
        if (sm_o !== pack_mm() || dec_o !== '0 || dec_vld_o !== 1'b0)
            fail("R1 reset state", 64'({dec_vld_o, dec_o, sm_o}), 64'(pack_mm()));
        rst_n = 1'b1;
        step(1'b1, '0);
        step(1'b1, '0);
        random_run(1500);
        repeat (5) step(1'b0, '0);
        repeat (20) step(1'b1, {(2*NS){5'd31}});
        random_run(1500);
        repeat (4) step(1'b0, '0);
        @(negedge clk);
        // R3: equal candidates occurred and were judged above
        checks++;
        if (ties == 0) fail("R3 no tie exercised", 64'(ties), 64'd1);
        // R5: wrapped comparisons where unsigned order would mislead
        checks++;
        if (wraps == 0) fail("R5 no wrapped comparison", 64'(wraps), 64'd1);
        // R8: every accepted cycle produced its own result
        checks++;
        if (exp_q.size() != 0) fail("R8 missing results", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule